// File: doc/BRIEF.md
# Interval Watchdog Timer

This block is a watchdog for a networking system-on-chip. A prescaler turns the system clock into a tick once every 10 ms. A 15-bit counter climbs by one on each tick. The watchdog expires when the counter has reached a programmed 15-bit limit and one more tick arrives. Software keeps the system alive by writing the single 32-bit service register before that happens. Every write clears the counter and restarts the prescaler phase. The same write loads a new limit and an action bit.

On expiry the block sets an expired flag, which stays set until the next write. If the action bit is set, the block also raises a reset request for exactly one clock cycle. When the action bit is clear, expiry only sets the flag. Reads return the live count, the limit and the action bit. The prescaler length is a parameter computed from the clock frequency, and a bench can override it with a small value.

Top module: `wdt_timer`

## Requirements
- R1: After reset the read word is 0x7FFF0000 (limit 0x7FFF in bits 30:16, action bit 31 clear, count 0 in bits 14:0), and `expired` and `sys_rst_req` are low.
- R2: After a write, or after reset is released, a tick occurs on every TICK_DIV-th rising clock edge. Each tick adds one to the count in bits 14:0 until expiry.
- R3: A write clears the count and the expired flag and restarts the tick phase. It loads bits 30:16 of the write data as the limit and bit 31 as the action bit, and both read back in the same positions.
- R4: Expiry happens on the first tick that finds the count equal to the limit, so a limit L expires on tick L+1 after the write. `expired` then stays high until the next write, and the count never exceeds the limit.
- R5: While expired, the count holds at the limit value and does not wrap.
- R6: A limit of zero expires on the first tick after the write.
- R7: `sys_rst_req` is high for exactly the one cycle after the expiring edge when the action bit is 1. It never rises when the action bit is 0.
- R8: Bit 15 of the read word is always zero, whatever was written to it.
- R9: A write on the same edge as a tick or an expiry takes precedence. The count reads 0, `expired` stays low and no reset request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Service-register write strobe |
| wr_data | input | 32 | Write word: action bit 31, limit 30:16 |
| rd_data | output | 32 | Read word: action 31, limit 30:16, zero 15, count 14:0 |
| expired | output | 1 | Sticky expiry flag |
| sys_rst_req | output | 1 | One-cycle system reset request |

## Verification
All results are registered, so every effect of a write appears one clock edge after the cycle in which `wr_en` is high. In the read word, the tick number k after a write lands on edge k*TICK_DIV after the write edge. Expiry, and any reset pulse, lands on edge (L+1)*TICK_DIV, and the pulse is gone one edge later. The bench counts edges since the last write, samples on the falling edge, and derives the read word, flag and pulse from that edge count alone. This also covers writes placed exactly on a tick edge or an expiry edge.

// File: rtl/wdt_timer.sv
module wdt_timer #(
  parameter int CLK_HZ   = 100_000_000,
  parameter int TICK_HZ  = 100,
  parameter int TICK_DIV = CLK_HZ / TICK_HZ
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  output logic        expired,
  output logic        sys_rst_req
);
  localparam int CW = 15;
  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  logic [PW-1:0] pre;
  logic [CW-1:0] count, limit;
  logic          act;

  wire tick = (pre == PW'(TICK_DIV - 1));
  wire hit  = tick && !expired && (count == limit);

  always_ff @(posedge clk) begin
    if (!rst_n)              pre <= '0;
    else if (wr_en || tick)  pre <= '0;
    else                     pre <= pre + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count   <= '0;
      limit   <= '1;
      act     <= 1'b0;
      expired <= 1'b0;
    end else if (wr_en) begin
      count   <= '0;
      limit   <= wr_data[30:16];
      act     <= wr_data[31];
      expired <= 1'b0;
    end else if (hit) begin
      expired <= 1'b1;
    end else if (tick && !expired) begin
      count <= count + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) sys_rst_req <= 1'b0;
    else        sys_rst_req <= hit && act && !wr_en;
  end

  assign rd_data = {act, limit, 1'b0, count};

  p_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    count <= limit);
  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (count == '0) && !expired);
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (expired && !wr_en) |=> expired && $stable(count));
  p_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req |=> !sys_rst_req);
  p_req_exp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req |-> expired && act);
endmodule

// File: tb/wdt_timer_test.sv
module wdt_timer_test;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 4;

  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic expired, sys_rst_req;

  int passed = 0, total = 0, el = 0;
  logic [14:0] t = 15'h7fff;
  logic en = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdt_timer #(.TICK_DIV(DIV)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .expired(expired), .sys_rst_req(sys_rst_req));

  function automatic logic [31:0] exp_rd(int e);
    int tk = e / DIV;
    logic [14:0] c = (tk > int'(t)) ? t : 15'(tk);
    return {en, t, 1'b0, c};
  endfunction
  function automatic logic exp_ex(int e);
    return (e / DIV) > int'(t);
  endfunction
  function automatic logic exp_req(int e);
    return en && (e == (int'(t) + 1) * DIV);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act === exp) passed++;
    else $display("FAIL %s: actual %h expected %h (el=%0d)", req, act, exp, el);
  endtask

  task automatic check_all();
    check("R2 R5", rd_data, exp_rd(el));
    check("R4 R6", 32'(expired), 32'(exp_ex(el)));
    check("R7", 32'(sys_rst_req), 32'(exp_req(el)));
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); el++;
      @(negedge clk); check_all();
    end
  endtask

  task automatic do_write(logic [31:0] d);
    wr_en = 1; wr_data = d;
    @(posedge clk);
    el = 0; t = d[30:16]; en = d[31];
    @(negedge clk);
    wr_en = 0;
    check("R3 R9", rd_data, exp_rd(0));
    check("R3 R9", 32'(expired), 32'b0);
    check("R8", 32'(rd_data[15]), 32'b0);
    check("R9", 32'(sys_rst_req), 32'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", passed, total);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240));
    repeat (3) @(negedge clk);
    rst_n = 1;
    el = 0;
    check("R1", rd_data, 32'h7fff_0000);
    check("R1", {30'b0, expired, sys_rst_req}, 32'b0);
    step(3 * DIV);
    // R6 R7: zero limit with reset action
    do_write({1'b1, 15'd0, 1'b1, 15'h1234});
    step(3 * DIV);
    // R5 R7: flag only, count holds
    do_write({1'b0, 15'd2, 16'h0});
    step(6 * DIV);
    // R9: write coincident with a tick edge
    do_write({1'b1, 15'd5, 16'h0});
    step(DIV - 1);
    do_write({1'b1, 15'd5, 16'h8000});
    step(DIV + 1);
    // R9: write coincident with expiry edge
    do_write({1'b1, 15'd0, 16'h0});
    step(DIV - 1);
    do_write({1'b1, 15'd1, 16'h0});
    step(3 * DIV);
    for (int k = 0; k < 40; k++) begin
      logic [31:0] d = $urandom;
      d[30:16] = 15'($urandom_range(0, 5));
      do_write(d);
      step($urandom_range(0, (int'(d[30:16]) + 3) * DIV));
    end
    $display("%0d/%0d checks passed", passed, total);
    $finish;
  end
endmodule